// File: doc/BRIEF.md
# Instruction Fetch Stage with One Delay Slot

This block is the front stage of a small two-stage 32-bit pipeline. It holds the program counter (PC) and reads instructions from its own byte-wide instruction store, which is separate from data storage. Each 32-bit instruction is built from four consecutive bytes, least significant byte first. When the execute stage signals a taken conditional branch or a jump, the PC is redirected. The instruction that follows the control transfer (the delay slot) has already been fetched by then, and it is always delivered. The stage never flushes.

The fetched word leaves the block on a valid/ready stream. `f_valid` is high whenever the stage is out of reset. A word is consumed on a cycle where `f_valid` and `f_ready` are both high. When `f_ready` is low the stage stalls: the PC, the word and `f_pc_plus4` hold steady, and redirect inputs are not consumed. The execute stage must keep a pending redirect asserted until the cycle in which the stage accepts it.

The redirect inputs are plain control pins. They are sampled in the cycle the delay slot is on the output. A branch offset is therefore taken relative to the delay slot's own address. The byte store is loaded through a synchronous preload port, while reads are combinational.

Top module: `ifetch_dslot`

## Requirements
- R1: While `rst` is high (synchronous, active high), `f_pc` becomes 0 and `f_valid` is low. After release, the first word presented is the one at address 0.
- R2: On an accepted cycle with no redirect, `f_pc` advances by 4. It always remains a multiple of 4.
- R3: `f_instr` equals `{byte[a+3], byte[a+2], byte[a+1], byte[a]}`, where `a` is `f_pc` modulo the store size. The lowest address supplies bits 7:0.
- R4: On an accepted cycle with `br_take` high and `jmp_take` low, the next PC is `f_pc + (sign-extended br_off << 2)`. `f_pc` at that point is the delay slot's address.
- R5: On an accepted cycle with `jmp_take` high, the next PC is `{f_pc[31:28], jmp_idx, 2'b00}`. The jump wins when `br_take` is also high.
- R6: `f_pc_plus4` equals `f_pc + 4`. While a jump-and-link is in execute, this value is the link address, which is the jump's address plus 8.
- R7: While `f_valid` is high and `f_ready` is low, `f_pc` and `f_instr` hold. Redirect inputs present only during the stall have no effect.
- R8: Store addresses wrap modulo the store size (1024 bytes by default). A PC of 0x400 reads the same bytes as PC 0.
- R9: A preload write (`pl_en`, `pl_addr`, `pl_byte`) takes effect at the clock edge. The change is visible on `f_instr` right after that edge, with no further latency.
- R10: A negative branch offset moves the PC backwards. For example, offset 0xFFFE from delay slot 0x104 gives 0xFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_en | input | 1 | Preload write enable |
| pl_addr | input | 10 | Preload byte address |
| pl_byte | input | 8 | Preload byte value |
| br_take | input | 1 | Execute stage: conditional branch taken |
| br_off | input | 16 | Branch word offset, signed |
| jmp_take | input | 1 | Execute stage: jump or jump-and-link taken |
| jmp_idx | input | 26 | Jump word index |
| f_valid | output | 1 | Fetched word is valid |
| f_ready | input | 1 | Consumer accepts the fetched word |
| f_instr | output | 32 | Fetched instruction word |
| f_pc | output | 32 | Address of the fetched word |
| f_pc_plus4 | output | 32 | Fetched address plus 4 (link value) |

## Verification
The PC and `f_pc_plus4` change exactly one rising edge after an accepted cycle. `f_instr` follows the PC combinationally in the same cycle, and a preload write shows on `f_instr` right after its own edge. The bench drives every input on the falling edge. It lets one rising edge pass, then samples all outputs at the next falling edge, so each result is read in the cycle it is due. Stall rows hold `f_ready` low across a full edge. This confirms that nothing moved and that a transient redirect was dropped.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  localparam int XLEN = 32;
  localparam int OFFW = 16;
  localparam int IDXW = 26;

  typedef struct packed {
    logic            jmp;
    logic [IDXW-1:0] idx;
    logic            br;
    logic [OFFW-1:0] off;
  } redir_t;

  // signed word offset -> byte displacement
  function automatic logic [XLEN-1:0] word_disp(input logic [OFFW-1:0] o);
    return {{(XLEN-OFFW-2){o[OFFW-1]}}, o, 2'b00};
  endfunction

endpackage

// File: rtl/ifetch_imem.sv
module ifetch_imem #(
  parameter int DEPTH = 1024,
  parameter int BPW   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int WW   = 8 * BPW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [WW-1:0] rd_word
);

  logic [7:0] bytes_q [DEPTH];

  // synchronous byte write
  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[wr_addr] <= wr_byte;
  end

  // combinational read, one lane per byte; lowest address lands in bits 7:0
  for (genvar k = 0; k < BPW; k++) begin : g_lane
    logic [AW-1:0] lane_addr;
    assign lane_addr            = rd_addr + AW'(k);
    assign rd_word[8*k +: 8]    = bytes_q[lane_addr];
  end

endmodule

// File: rtl/ifetch_target.sv
module ifetch_target
  import ifetch_pkg::*;
(
  input  logic [XLEN-1:0] cur_pc,
  input  redir_t          redir,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] next_pc
);

  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;

  always_comb begin
    seq_pc  = cur_pc + XLEN'(4);
    br_tgt  = cur_pc + word_disp(redir.off);
    jmp_tgt = {cur_pc[XLEN-1:XLEN-4], redir.idx, 2'b00};
    if (redir.jmp)     next_pc = jmp_tgt;
    else if (redir.br) next_pc = br_tgt;
    else               next_pc = seq_pc;
  end

endmodule

// File: rtl/ifetch_pc.sv
module ifetch_pc
  import ifetch_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc,
  output logic            valid
);

  logic [XLEN-1:0] pc_q;
  logic            vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (advance) pc_q <= next_pc;
    end
  end

  assign pc    = pc_q;
  assign valid = vld_q;

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0 && !vld_q));

  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !advance) |=> $stable(pc_q));

endmodule

// File: rtl/ifetch_dslot.sv
module ifetch_dslot
  import ifetch_pkg::*;
#(
  parameter int IMEM_BYTES = 1024,
  localparam int AW        = $clog2(IMEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl_en,
  input  logic [AW-1:0]     pl_addr,
  input  logic [7:0]        pl_byte,
  input  logic              br_take,
  input  logic [OFFW-1:0]   br_off,
  input  logic              jmp_take,
  input  logic [IDXW-1:0]   jmp_idx,
  output logic              f_valid,
  input  logic              f_ready,
  output logic [XLEN-1:0]   f_instr,
  output logic [XLEN-1:0]   f_pc,
  output logic [XLEN-1:0]   f_pc_plus4
);

  redir_t          redir;
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] nxt;
  logic [XLEN-1:0] seq;
  logic            vld;
  logic            adv;

  assign redir = '{jmp: jmp_take, idx: jmp_idx, br: br_take, off: br_off};
  assign adv   = vld & f_ready;

  ifetch_target u_tgt (
    .cur_pc  (pc),
    .redir   (redir),
    .seq_pc  (seq),
    .next_pc (nxt)
  );

  ifetch_pc u_pc (
    .clk     (clk),
    .rst     (rst),
    .advance (adv),
    .next_pc (nxt),
    .pc      (pc),
    .valid   (vld)
  );

  ifetch_imem #(.DEPTH(IMEM_BYTES), .BPW(XLEN/8)) u_mem (
    .clk     (clk),
    .wr_en   (pl_en),
    .wr_addr (pl_addr),
    .wr_byte (pl_byte),
    .rd_addr (pc[AW-1:0]),
    .rd_word (f_instr)
  );

  assign f_valid    = vld;
  assign f_pc       = pc;
  assign f_pc_plus4 = seq;

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !br_take && !jmp_take) |=> (pc == $past(pc) + XLEN'(4)));

  p_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && br_take && !jmp_take) |=> (pc == $past(pc) + word_disp($past(br_off))));

  p_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && jmp_take) |=> (pc[XLEN-5:0] == {$past(jmp_idx), 2'b00}
                           && pc[XLEN-1:XLEN-4] == $past(pc[XLEN-1:XLEN-4])));

endmodule

// File: tb/sim_ifetch_dslot.sv
module sim_ifetch_dslot;

  localparam int CLK_P = 10;
  localparam int NB    = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pl_en = 1'b0;
  logic [9:0]  pl_addr = '0;
  logic [7:0]  pl_byte = '0;
  logic        br_take = 1'b0;
  logic [15:0] br_off = '0;
  logic        jmp_take = 1'b0;
  logic [25:0] jmp_idx = '0;
  logic        f_ready = 1'b0;
  logic        f_valid;
  logic [31:0] f_instr, f_pc, f_pc_plus4;

  int  n_run = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] model [NB];

  always #(CLK_P/2) clk = ~clk;

  ifetch_dslot u0 (
    .clk(clk), .rst(rst), .pl_en(pl_en), .pl_addr(pl_addr), .pl_byte(pl_byte),
    .br_take(br_take), .br_off(br_off), .jmp_take(jmp_take), .jmp_idx(jmp_idx),
    .f_valid(f_valid), .f_ready(f_ready), .f_instr(f_instr), .f_pc(f_pc),
    .f_pc_plus4(f_pc_plus4)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] p);
    int b;
    b = int'(p % NB);
    return {model[(b+3)%NB], model[(b+2)%NB], model[(b+1)%NB], model[b]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {ready, br, off[15:0], jmp, idx[25:0], expected pc after the edge}
  localparam logic [76:0] VEC [13] = '{
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_0004},  // R2 step
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_0008},  // R2 step
    {1'b1, 1'b1, 16'h0003, 1'b0, 26'h0,   32'h0000_0014},  // R4 from slot 8
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_0018},  // R2
    {1'b0, 1'b1, 16'h0064, 1'b0, 26'h0,   32'h0000_0018},  // R7 stall, branch dropped
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_001C},  // R7 resumes with +4
    {1'b1, 1'b0, 16'h0000, 1'b1, 26'h40,  32'h0000_0100},  // R5 jump (link 0x20 = 0x18+8, R6)
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_0104},  // R2
    {1'b1, 1'b1, 16'hFFFE, 1'b0, 26'h0,   32'h0000_00FC},  // R10 backwards
    {1'b1, 1'b1, 16'h0005, 1'b1, 26'hFF,  32'h0000_03FC},  // R5 jump beats branch
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_0400},  // R8 wrap
    {1'b1, 1'b0, 16'h0000, 1'b0, 26'h0,   32'h0000_0404},  // R8
    {1'b1, 1'b1, 16'h7FFF, 1'b0, 26'h0,   32'h0002_0400}   // R4 max offset, R8
  };

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    // preload under reset, model kept in parallel
    for (int a = 0; a < NB; a++) begin
      @(negedge clk);
      model[a] = 8'((a * 37 + 11) & 8'hFF);
      pl_en    = 1'b1;
      pl_addr  = 10'(a);
      pl_byte  = model[a];
    end
    @(negedge clk);
    pl_en = 1'b0;
    @(negedge clk);
    chk("R1 pc in reset", f_pc, 32'h0);
    chk("R1 valid in reset", {31'b0, f_valid}, 32'h0);
    chk("R3 word at 0", f_instr, exp_word(32'h0));

    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 valid after release", {31'b0, f_valid}, 32'h1);
    chk("R1 first pc", f_pc, 32'h0);

    for (int i = 0; i < 13; i++) begin
      f_ready  = VEC[i][76];
      br_take  = VEC[i][75];
      br_off   = VEC[i][74:59];
      jmp_take = VEC[i][58];
      jmp_idx  = VEC[i][57:32];
      @(posedge clk);
      @(negedge clk);
      br_take  = 1'b0;
      jmp_take = 1'b0;
      chk($sformatf("R2/R4/R5/R7 pc row %0d", i), f_pc, VEC[i][31:0]);
      chk($sformatf("R3/R8 instr row %0d", i), f_instr, exp_word(VEC[i][31:0]));
      chk($sformatf("R6 pc_plus4 row %0d", i), f_pc_plus4, VEC[i][31:0] + 32'd4);
    end

    // R9: preload while stalled, visible right after the write edge
    f_ready = 1'b0;
    pl_en   = 1'b1;
    pl_addr = 10'h001;
    pl_byte = 8'hA5;
    model[1] = 8'hA5;
    @(posedge clk);
    @(negedge clk);
    pl_en = 1'b0;
    chk("R9 preload visible", f_instr, exp_word(32'h0002_0400));
    chk("R7 pc held during stall", f_pc, 32'h0002_0400);

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc after mid-run reset", f_pc, 32'h0);
    chk("R1 valid after mid-run reset", {31'b0, f_valid}, 32'h0);
    rst = 1'b0;
    f_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc holds on first valid cycle", f_pc, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 step after reset", f_pc, 32'h4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule